// File: doc/BRIEF.md
# Page-wide Hamming ECC engine

The engine sits beside a NAND flash data bus and watches every data word that goes to or from the flash. It builds one single-error-correcting, double-error-detecting code over a whole page, in a single step, for data pages of 512, 1024, 2048 or 4096 bytes on an 8-bit or a 16-bit bus. Command and address cycles, and strobes seen while the engine is disabled, are not counted.

On a write, software reads the two 16-bit code halves once the last data word has passed and stores them as four spare bytes. On a read, those four stored bytes have to follow the last data word directly. The engine takes them as the check code and compares them with its own result. It then tells apart a clean page, a single error in the data (given as a 12-bit word address and a 4-bit bit offset), a single error inside the stored code, and an uncorrectable page. An erased page, all ones in both data and code, is reported as an uncorrectable page whose location is all ones, so software can recognise it. After the code words the engine is ready for the next page at once.

Registers (3-bit address, 16-bit data; a read returns its value on `reg_rdata` in the cycle after `reg_rd`): 0 control (bit0 writes a one-shot accumulation clear, bit1 enable), 1 mode (bits[1:0] page size, bit2 16-bit bus), 2 status (bit0 any error, bit1 multiple errors, bit2 error in code only), 3 parity half A, 4 parity half B.

Top module: `page_ecc_engine`

## Requirements
- R1: Mode bits[1:0] values 0, 1, 2 and 3 select data pages of 512, 1024, 2048 and 4096 bytes. The data phase lasts exactly that many bytes divided by the bus width in bytes, and the check code follows it: four bytes on an 8-bit bus, two words on a 16-bit bus.
- R2: When the data phase ends, register 3 holds the XOR of the location {word index[11:0], bit index[3:0]} of every set data bit, and register 4 holds the XOR of the bitwise complement of those locations.
- R3: When the check code matches the computed code, status reads 0 after the page.
- R4: When the data holds one flipped bit, status reads 1 and register 3 gives bits[3:0] = bit offset and bits[15:4] = word address of that bit.
- R5: When exactly one bit of the stored code is flipped, status reads 5 (any error and code-only) and register 4 shows that bit.
- R6: When the data holds two flipped bits, status reads 3 (any error and multiple errors).
- R7: An erased page (all data ones, all four code bytes 0xFF) gives status 3 and reads 0xFFFF in register 3.
- R8: With mode bit2 set, the bus is 16 bits wide, bit offsets run from 0 to 15, and the code is taken as the word for register 3 followed by the word for register 4. On an 8-bit bus the byte order is reg3[7:0], reg3[15:8], reg4[7:0], reg4[15:8].
- R9: A strobe with the command flag or the address flag high, or one seen while control bit1 is 0, changes neither the code nor the word count.
- R10: Writing control bit0 = 1 discards all accumulation and restarts the page at word 0.
- R11: Reset leaves the control, mode and status registers at 0. Reading status clears it. The engine starts the next page right after the code words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Registered read data |
| snp_stb | input | 1 | Flash data strobe being snooped |
| snp_cmd | input | 1 | Current cycle is a command cycle |
| snp_addr | input | 1 | Current cycle is an address cycle |
| snp_data | input | 16 | Snooped bus word (low byte on an 8-bit bus) |

## Verification
The case hardest to reach from the ports is an erased page. It requires a full 4096-byte page of ones followed by four 0xFF code bytes, and only then do the erased-page marker and the multiple-error flag appear together. The bench drives that whole page directly. It also places random single and double bit flips at locations drawn from a fixed-seed generator, on both bus widths. Command and address noise, and strobes sent while the engine is disabled, are mixed into the middle of a page. A clear is issued after a partial page of garbage. Both of these only come out right if the word count stays exact up to the code phase.

// File: rtl/ecc_eng_pkg.sv
package ecc_eng_pkg;
  typedef enum logic [2:0] {
    RA_CTRL = 3'd0,
    RA_MODE = 3'd1,
    RA_STAT = 3'd2,
    RA_PARA = 3'd3,
    RA_PARB = 3'd4
  } reg_addr_e;

  typedef enum logic {
    PH_DATA = 1'b0,
    PH_CODE = 1'b1
  } phase_e;

  typedef struct packed {
    logic code_only;
    logic multi;
    logic any;
  } stat_t;
endpackage

// File: rtl/ecc_accum.sv
module ecc_accum
  import ecc_eng_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int WADDR_W  = 12,
  parameter int MIN_LOG2 = 9,
  localparam int BIT_W   = $clog2(DATA_W),
  localparam int LOC_W   = WADDR_W + BIT_W,
  localparam int HALF    = DATA_W / 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              take,
  input  logic              wide,
  input  logic [1:0]        size,
  input  logic [DATA_W-1:0] din,
  output logic [LOC_W-1:0]  code_a,
  output logic [LOC_W-1:0]  code_b,
  output logic              data_done,
  output logic [LOC_W-1:0]  chk_a,
  output logic [LOC_W-1:0]  chk_b,
  output logic              chk_done
);
  phase_e             phase;
  logic [WADDR_W-1:0] cnt;
  logic [1:0]         cidx;
  logic [LOC_W-1:0]   acc_a, acc_b;
  logic [LOC_W-1:0]   lx;
  logic               par;
  logic [4:0]         sh;
  logic [WADDR_W:0]   words_m1;
  logic               data_last, code_last;

  always_comb begin
    sh       = 5'(MIN_LOG2) + 5'(size) - 5'(wide);
    words_m1 = ({{WADDR_W{1'b0}}, 1'b1} << sh) - 1'b1;
    data_last = (cnt == words_m1[WADDR_W-1:0]);
    code_last = wide ? (cidx == 2'd1) : (cidx == 2'd3);
  end

  // Location XOR of all set bits in the current word, plus its bit parity
  always_comb begin
    lx  = '0;
    par = 1'b0;
    for (int j = 0; j < DATA_W; j++) begin
      if ((wide || j < HALF) && din[j]) begin
        lx  = lx ^ {cnt, BIT_W'(j)};
        par = ~par;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      phase     <= PH_DATA;
      cnt       <= '0;
      cidx      <= '0;
      acc_a     <= '0;
      acc_b     <= '0;
      data_done <= 1'b0;
      chk_done  <= 1'b0;
      if (rst) begin
        code_a <= '0;
        code_b <= '0;
        chk_a  <= '0;
        chk_b  <= '0;
      end
    end else begin
      data_done <= 1'b0;
      chk_done  <= 1'b0;
      if (take) begin
        if (phase == PH_DATA) begin
          if (data_last) begin
            code_a    <= acc_a ^ lx;
            code_b    <= acc_b ^ lx ^ {LOC_W{par}};
            acc_a     <= '0;
            acc_b     <= '0;
            cnt       <= '0;
            cidx      <= '0;
            phase     <= PH_CODE;
            data_done <= 1'b1;
          end else begin
            acc_a <= acc_a ^ lx;
            acc_b <= acc_b ^ lx ^ {LOC_W{par}};
            cnt   <= cnt + 1'b1;
          end
        end else begin
          if (wide) begin
            if (cidx == 2'd0) chk_a <= din[LOC_W-1:0];
            else              chk_b <= din[LOC_W-1:0];
          end else begin
            case (cidx)
              2'd0:    chk_a[HALF-1:0]      <= din[HALF-1:0];
              2'd1:    chk_a[LOC_W-1:HALF]  <= din[HALF-1:0];
              2'd2:    chk_b[HALF-1:0]      <= din[HALF-1:0];
              default: chk_b[LOC_W-1:HALF]  <= din[HALF-1:0];
            endcase
          end
          if (code_last) begin
            cidx     <= '0;
            phase    <= PH_DATA;
            chk_done <= 1'b1;
          end else begin
            cidx <= cidx + 1'b1;
          end
        end
      end
    end
  end

  assert_cnt_bound_R1: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_DATA) |-> ({1'b0, cnt} <= words_m1));

  assert_done_excl_R1: assert property (@(posedge clk) disable iff (rst)
    !(data_done && chk_done));

  assert_code_idx_R8: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_CODE && wide) |-> (cidx <= 2'd1));

  assert_clear_R10: assert property (@(posedge clk) disable iff (rst)
    clr |=> (cnt == '0 && phase == PH_DATA && acc_a == '0 && acc_b == '0));

  assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (!take && !clr) |=> ($stable(cnt) && $stable(acc_a) && $stable(cidx)));
endmodule

// File: rtl/ecc_classify.sv
module ecc_classify
  import ecc_eng_pkg::*;
#(
  parameter int LOC_W = 16,
  localparam int CW   = $clog2(2 * LOC_W + 1)
) (
  input  logic [LOC_W-1:0] code_a,
  input  logic [LOC_W-1:0] code_b,
  input  logic [LOC_W-1:0] chk_a,
  input  logic [LOC_W-1:0] chk_b,
  output logic [LOC_W-1:0] syn_a,
  output logic [LOC_W-1:0] syn_b,
  output stat_t            stat
);
  logic [CW-1:0] ones;

  always_comb begin
    syn_a = code_a ^ chk_a;
    syn_b = code_b ^ chk_b;
    ones  = CW'($countones({syn_a, syn_b}));
    stat  = '0;
    if (ones == CW'(0)) begin
      stat = '0;
    end else if (ones == CW'(1)) begin
      stat.any       = 1'b1;
      stat.code_only = 1'b1;
    end else if ((syn_a ^ syn_b) == {LOC_W{1'b1}}) begin
      stat.any = 1'b1;
    end else begin
      stat.any   = 1'b1;
      stat.multi = 1'b1;
    end
  end
endmodule

// File: rtl/ecc_regs.sv
module ecc_regs
  import ecc_eng_pkg::*;
#(
  parameter int REG_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             reg_wr,
  input  logic             reg_rd,
  input  logic [2:0]       reg_addr,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  input  logic             data_done,
  input  logic [REG_W-1:0] code_a,
  input  logic [REG_W-1:0] code_b,
  input  logic             chk_done,
  input  logic [REG_W-1:0] syn_a,
  input  logic [REG_W-1:0] syn_b,
  input  stat_t            stat_in,
  output logic             en,
  output logic             clr,
  output logic [1:0]       size,
  output logic             wide
);
  stat_t            stat;
  logic [REG_W-1:0] disp_a, disp_b;
  logic             rd_stat;

  assign clr     = reg_wr && (reg_addr == RA_CTRL) && reg_wdata[0];
  assign rd_stat = reg_rd && (reg_addr == RA_STAT);

  always_ff @(posedge clk) begin
    if (rst) begin
      en   <= 1'b0;
      size <= 2'd0;
      wide <= 1'b0;
    end else if (reg_wr) begin
      if (reg_addr == RA_CTRL) en <= reg_wdata[1];
      if (reg_addr == RA_MODE) begin
        size <= reg_wdata[1:0];
        wide <= reg_wdata[2];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stat   <= '0;
      disp_a <= '0;
      disp_b <= '0;
    end else begin
      if (chk_done) begin
        stat   <= stat_in;
        disp_a <= syn_a;
        disp_b <= syn_b;
      end else begin
        if (rd_stat) stat <= '0;
        if (data_done) begin
          disp_a <= code_a;
          disp_b <= code_b;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
    end else if (reg_rd) begin
      case (reg_addr)
        RA_CTRL: reg_rdata <= REG_W'({en, 1'b0});
        RA_MODE: reg_rdata <= REG_W'({wide, size});
        RA_STAT: reg_rdata <= REG_W'(stat);
        RA_PARA: reg_rdata <= disp_a;
        RA_PARB: reg_rdata <= disp_b;
        default: reg_rdata <= '0;
      endcase
    end
  end

  assert_multi_any_R6: assert property (@(posedge clk) disable iff (rst)
    stat.multi |-> stat.any);

  assert_code_only_R5: assert property (@(posedge clk) disable iff (rst)
    stat.code_only |-> (stat.any && !stat.multi));

  assert_rd_clear_R11: assert property (@(posedge clk) disable iff (rst)
    (rd_stat && !chk_done) |=> (stat == '0));

  assert_load_R3: assert property (@(posedge clk) disable iff (rst)
    chk_done |=> (stat == $past(stat_in)));
endmodule

// File: rtl/page_ecc_engine.sv
module page_ecc_engine
  import ecc_eng_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int WADDR_W  = 12,
  parameter int MIN_LOG2 = 9,
  localparam int LOC_W   = WADDR_W + $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [2:0]        reg_addr,
  input  logic [LOC_W-1:0]  reg_wdata,
  output logic [LOC_W-1:0]  reg_rdata,
  input  logic              snp_stb,
  input  logic              snp_cmd,
  input  logic              snp_addr,
  input  logic [DATA_W-1:0] snp_data
);
  logic             en, clr, wide, take;
  logic [1:0]       size;
  logic [LOC_W-1:0] code_a, code_b, chk_a, chk_b, syn_a, syn_b;
  logic             data_done, chk_done;
  stat_t            stat_c;

  assign take = snp_stb && en && !snp_cmd && !snp_addr;

  ecc_accum #(.DATA_W(DATA_W), .WADDR_W(WADDR_W), .MIN_LOG2(MIN_LOG2)) u_accum (
    .clk(clk), .rst(rst), .clr(clr), .take(take), .wide(wide), .size(size),
    .din(snp_data), .code_a(code_a), .code_b(code_b), .data_done(data_done),
    .chk_a(chk_a), .chk_b(chk_b), .chk_done(chk_done)
  );

  ecc_classify #(.LOC_W(LOC_W)) u_classify (
    .code_a(code_a), .code_b(code_b), .chk_a(chk_a), .chk_b(chk_b),
    .syn_a(syn_a), .syn_b(syn_b), .stat(stat_c)
  );

  ecc_regs #(.REG_W(LOC_W)) u_regs (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .data_done(data_done),
    .code_a(code_a), .code_b(code_b), .chk_done(chk_done), .syn_a(syn_a),
    .syn_b(syn_b), .stat_in(stat_c), .en(en), .clr(clr), .size(size), .wide(wide)
  );
endmodule

// File: tb/tb_page_ecc_engine.sv
module tb_page_ecc_engine;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        snp_stb = 1'b0, snp_cmd = 1'b0, snp_addr = 1'b0;
  logic [15:0] snp_data = '0;

  int n_chk = 0, n_fail = 0, cyc = 0;
  logic [15:0] pg [0:4095];
  logic [15:0] ma, mb, rv;

  always #10 clk = ~clk;

  page_ecc_engine dut (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .snp_stb(snp_stb),
    .snp_cmd(snp_cmd), .snp_addr(snp_addr), .snp_data(snp_data)
  );

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk); reg_rd = 1'b1; reg_addr = a;
    @(negedge clk); reg_rd = 1'b0; d = reg_rdata;
  endtask

  task automatic snoop(input logic [15:0] d, input logic c, input logic ad);
    @(negedge clk); snp_stb = 1'b1; snp_data = d; snp_cmd = c; snp_addr = ad;
    @(posedge clk); #1 snp_stb = 1'b0; snp_cmd = 1'b0; snp_addr = 1'b0;
  endtask

  function automatic int nwords(input int size, input bit wide);
    return (512 << size) >> (wide ? 1 : 0);
  endfunction

  function automatic void model(input int n, input bit wide);
    ma = '0; mb = '0;
    for (int w = 0; w < n; w++)
      for (int j = 0; j < (wide ? 16 : 8); j++)
        if (pg[w][j]) begin
          ma = ma ^ {12'(w), 4'(j)};
          mb = mb ^ ~{12'(w), 4'(j)};
        end
  endfunction

  task automatic fill(input int n, input bit wide);
    for (int i = 0; i < n; i++) pg[i] = wide ? 16'($urandom) : 16'($urandom & 8'hFF);
  endtask

  // noise: 1 = inject command/address/disabled strobes mid-page (R9)
  task automatic send_page(input int n, input bit noise);
    for (int i = 0; i < n; i++) begin
      if (noise && i == 5) begin
        snoop(16'h00A5, 1'b1, 1'b0);
        snoop(16'h005A, 1'b0, 1'b1);
      end
      if (noise && i == 9) begin
        wr(3'd0, 16'h0000);
        snoop(16'h00FF, 1'b0, 1'b0);
        wr(3'd0, 16'h0002);
      end
      snoop(pg[i], 1'b0, 1'b0);
    end
  endtask

  task automatic send_code(input bit wide, input logic [15:0] a, input logic [15:0] b);
    if (wide) begin
      snoop(a, 1'b0, 1'b0); snoop(b, 1'b0, 1'b0);
    end else begin
      snoop({8'h00, a[7:0]}, 1'b0, 1'b0); snoop({8'h00, a[15:8]}, 1'b0, 1'b0);
      snoop({8'h00, b[7:0]}, 1'b0, 1'b0); snoop({8'h00, b[15:8]}, 1'b0, 1'b0);
    end
    repeat (3) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=<150000", cyc);
      finish_run();
    end
  end

  initial begin
    int n, w, b, w2;
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // Reset state (R11)
    rd(3'd0, rv); check("R11 reset ctrl", rv, 16'h0000);
    rd(3'd1, rv); check("R11 reset mode", rv, 16'h0000);
    rd(3'd2, rv); check("R11 reset status", rv, 16'h0000);

    // 8-bit, 512 bytes: write path code and clean read (R1 R2 R3)
    wr(3'd1, 16'h0000); wr(3'd0, 16'h0002);
    rd(3'd1, rv); check("R1 mode readback", rv, 16'h0000);
    n = nwords(0, 0); fill(n, 0); model(n, 0);
    send_page(n, 0);
    repeat (2) @(negedge clk);
    rd(3'd3, rv); check("R2 code half A", rv, ma);
    rd(3'd4, rv); check("R2 code half B", rv, mb);
    send_code(0, ma, mb);
    rd(3'd2, rv); check("R3 clean page status", rv, 16'h0000);

    // single data error (R4) then status read clears (R11)
    fill(n, 0); model(n, 0);
    w = $urandom % n; b = $urandom % 8;
    pg[w][b] = ~pg[w][b];
    send_page(n, 0); send_code(0, ma, mb);
    rd(3'd2, rv); check("R4 single data error status", rv, 16'h0001);
    rd(3'd3, rv); check("R4 error location", rv, {12'(w), 4'(b)});
    rd(3'd2, rv); check("R11 status cleared by read", rv, 16'h0000);

    // single error in stored code (R5)
    fill(n, 0); model(n, 0);
    b = $urandom % 16;
    send_page(n, 0); send_code(0, ma, mb ^ (16'h1 << b));
    rd(3'd2, rv); check("R5 code-only status", rv, 16'h0005);
    rd(3'd4, rv); check("R5 code bit shown", rv, 16'h1 << b);

    // two data errors (R6)
    fill(n, 0); model(n, 0);
    w = $urandom % n; w2 = (w + 1 + ($urandom % (n - 1))) % n; b = $urandom % 8;
    pg[w][b] = ~pg[w][b];
    pg[w2][(b + 3) % 8] = ~pg[w2][(b + 3) % 8];
    send_page(n, 0); send_code(0, ma, mb);
    rd(3'd2, rv); check("R6 double error status", rv, 16'h0003);

    // 2048-byte page with command/address/disabled noise (R9 R1)
    wr(3'd1, 16'h0002);
    n = nwords(2, 0); fill(n, 0); model(n, 0);
    send_page(n, 1);
    repeat (2) @(negedge clk);
    rd(3'd3, rv); check("R9 code A unaffected by noise", rv, ma);
    rd(3'd4, rv); check("R9 code B unaffected by noise", rv, mb);
    send_code(0, ma, mb);
    rd(3'd2, rv); check("R9 R1 clean after noise", rv, 16'h0000);

    // clear discards partial garbage (R10)
    wr(3'd1, 16'h0000);
    n = nwords(0, 0);
    for (int i = 0; i < 7; i++) snoop(16'($urandom & 8'hFF), 1'b0, 1'b0);
    wr(3'd0, 16'h0003);
    fill(n, 0); model(n, 0);
    send_page(n, 0);
    repeat (2) @(negedge clk);
    rd(3'd3, rv); check("R10 code after clear", rv, ma);
    send_code(0, ma, mb);
    rd(3'd2, rv); check("R10 clean after clear", rv, 16'h0000);

    // 16-bit bus, 1024 bytes (R8)
    wr(3'd1, 16'h0005);
    n = nwords(1, 1); fill(n, 1); model(n, 1);
    send_page(n, 0);
    repeat (2) @(negedge clk);
    rd(3'd3, rv); check("R8 wide code A", rv, ma);
    rd(3'd4, rv); check("R8 wide code B", rv, mb);
    send_code(1, ma, mb);
    rd(3'd2, rv); check("R8 wide clean", rv, 16'h0000);
    fill(n, 1); model(n, 1);
    w = $urandom % n; b = 8 + ($urandom % 8);
    pg[w][b] = ~pg[w][b];
    send_page(n, 0); send_code(1, ma, mb);
    rd(3'd2, rv); check("R8 wide single error status", rv, 16'h0001);
    rd(3'd3, rv); check("R8 wide high bit location", rv, {12'(w), 4'(b)});

    // erased 4096-byte page on 8-bit bus (R7 R1)
    wr(3'd1, 16'h0003);
    n = nwords(3, 0);
    for (int i = 0; i < n; i++) pg[i] = 16'h00FF;
    send_page(n, 0); send_code(0, 16'hFFFF, 16'hFFFF);
    rd(3'd2, rv); check("R7 erased page status", rv, 16'h0003);
    rd(3'd3, rv); check("R7 erased location all ones", rv, 16'hFFFF);

    // next page re-armed straight away (R11)
    wr(3'd1, 16'h0000);
    n = nwords(0, 0); fill(n, 0); model(n, 0);
    send_page(n, 0); send_code(0, ma, mb);
    rd(3'd2, rv); check("R11 re-armed clean page", rv, 16'h0000);

    finish_run();
  end
endmodule